// File: doc/BRIEF.md
# UART Interrupt Request Combiner

This block merges the five interrupt conditions of a UART into a single active-high request line for the CPU. Each condition passes only when its bit in a 4-bit enable register is set. The block also presents a 4-bit identification code that names the most urgent pending condition, so that the service routine can read one value and branch straight to the right handler.

Four of the conditions are levels that come from the detection logic around the block: receiver line error, received data available, character timeout and modem status change. These inputs fall when the CPU services them, and the request follows them. The transmit-holding-register-empty condition needs a pending flag inside this block. The flag is set when the register becomes empty, or when software enables the interrupt while the register is already empty. It is cleared when the CPU reads an identification code that names it, or when the CPU writes the transmit register. The character timeout counts only while the FIFO-mode flag is high.

The request and the code are combinational from the inputs and the pending flag. The flag changes on the rising clock edge after its cause. Reset is synchronous and active-low. While reset is held, the request is low and the code reports that nothing is pending.

Top module: `uart_irq_combiner`

## Requirements
- R1: `irq_o` is 1 exactly when at least one enabled source is active. The enable mapping is: `ier_i[0]` for data available and timeout, `ier_i[1]` for transmit empty, `ier_i[2]` for line error, `ier_i[3]` for modem status. A source whose enable bit is 0 does not affect `irq_o` or `iid_o`.
- R2: The character-timeout source is ignored while `fifo_mode_i` is 0.
- R3: When several enabled sources are active, the code names the highest one. The order from highest to lowest is line error, data available, timeout, transmit empty, modem status.
- R4: The codes are: line error 4'b0110, data available 4'b0100, timeout 4'b1100, transmit empty 4'b0010, modem status 4'b0000.
- R5: With no enabled source active, `iid_o` is 4'b0001 and `irq_o` is 0. In every other case `iid_o[0]` is 0.
- R6: A 0-to-1 change of `thr_empty_i` sets the transmit-empty pending flag at the next rising clock edge.
- R7: A 0-to-1 change of `ier_i[1]` while `thr_empty_i` is 1 sets the pending flag at the next rising clock edge.
- R8: A cycle with `id_read_i` high while `iid_o` is 4'b0010 clears the pending flag. A read that reports another code leaves the flag set.
- R9: A cycle with `thr_write_i` high clears the pending flag, and this takes precedence over any set condition in the same cycle.
- R10: While `rst_n` is 0, `irq_o` is 0 and `iid_o` is 4'b0001. A synchronous reset clears the pending flag.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_err_i | input | 1 | Receiver line error condition (level) |
| rx_avail_i | input | 1 | Received data available condition (level) |
| char_tmo_i | input | 1 | Character timeout condition (level) |
| thr_empty_i | input | 1 | Transmit holding register is empty (level) |
| modem_chg_i | input | 1 | Modem status change condition (level) |
| fifo_mode_i | input | 1 | FIFO mode enabled |
| ier_i | input | 4 | Per-source interrupt enable bits |
| id_read_i | input | 1 | CPU reads the identification code this cycle |
| thr_write_i | input | 1 | CPU writes the transmit holding register this cycle |
| irq_o | output | 1 | Combined interrupt request, active high |
| iid_o | output | 4 | Prioritized interrupt identification code |

## Verification
On every cycle the assertions check three things: the request agrees with the no-pending bit of the code, no timeout code appears outside FIFO mode, and an enabled line error always wins. On every clock edge they also check that a transmit-register write clears the pending flag and that an empty edge sets it. The bench scenarios cover the rest. These are the full priority ladder walked down one source at a time, the setting of the flag when its enable rises, the difference between a code read that reports transmit-empty and one that reports a higher source, and the reset state.

// File: rtl/uart_irq_pkg.sv
// Package: shared widths, enable-bit positions and identification codes
// for the UART interrupt combiner. It assumes a 4-bit enable register and
// a 4-bit identification code whose bit 0 is 1 when nothing is pending.
package uart_irq_pkg;
    localparam int IER_W = 4;
    localparam int IID_W = 4;

    // Enable bit positions
    localparam int EN_RX   = 0;   // data available and timeout
    localparam int EN_THR  = 1;   // transmit empty
    localparam int EN_LINE = 2;   // line error
    localparam int EN_MDM  = 3;   // modem status

    typedef enum logic [IID_W-1:0] {
        IID_LINE = 4'b0110,
        IID_RX   = 4'b0100,
        IID_TMO  = 4'b1100,
        IID_THR  = 4'b0010,
        IID_MDM  = 4'b0000,
        IID_NONE = 4'b0001
    } iid_e;
endpackage

// File: rtl/uart_irq_thr_tracker.sv
// Module: holds the transmit-empty pending flag.
// The flag is set when the empty condition rises, or when its enable rises
// while the register is already empty. It is cleared by a transmit-register
// write, which wins over everything else, or by a code read that reports
// transmit-empty. Assumes single-cycle strobes and synchronous active-low reset.
module uart_irq_thr_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic thr_empty_i,
    input  logic thr_en_i,
    input  logic thr_write_i,
    input  logic id_read_i,
    input  logic id_is_thr_i,
    output logic pend_o
);
    logic empty_q;
    logic en_q;
    logic pend_q;
    logic set_c;

    // Purpose: combine the two set causes into one set term.
    always_comb begin
        set_c = (thr_empty_i && !empty_q) || (thr_en_i && !en_q && thr_empty_i);
    end

    // Purpose: keep the previous empty and enable values and update the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            en_q    <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            empty_q <= thr_empty_i;
            en_q    <= thr_en_i;
            if (thr_write_i)
                pend_q <= 1'b0;
            else if (set_c)
                pend_q <= 1'b1;
            else if (id_read_i && id_is_thr_i)
                pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // A transmit-register write always leaves the flag clear.
    assert_thr_write_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        thr_write_i |=> !pend_o);

    // An empty rising edge without a write sets the flag.
    assert_thr_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_empty_i && !empty_q && !thr_write_i) |=> pend_o);
endmodule

// File: rtl/uart_irq_prio_enc.sv
// Module: masks the sources with their enable bits, gates the timeout with
// FIFO mode, and encodes the highest pending source into the identification
// code. Purely combinational. Assumes all condition inputs are levels.
module uart_irq_prio_enc
    import uart_irq_pkg::*;
(
    input  logic             line_err_i,
    input  logic             rx_avail_i,
    input  logic             char_tmo_i,
    input  logic             thr_pend_i,
    input  logic             modem_chg_i,
    input  logic             fifo_mode_i,
    input  logic [IER_W-1:0] ier_i,
    output logic             irq_o,
    output logic [IID_W-1:0] iid_o,
    output logic             is_thr_o
);
    logic line_c, rx_c, tmo_c, thr_c, mdm_c;
    iid_e code_c;

    // Purpose: qualify each source with its enable bit (timeout also with FIFO mode).
    always_comb begin
        line_c = line_err_i  && ier_i[EN_LINE];
        rx_c   = rx_avail_i  && ier_i[EN_RX];
        tmo_c  = char_tmo_i  && ier_i[EN_RX] && fifo_mode_i;
        thr_c  = thr_pend_i  && ier_i[EN_THR];
        mdm_c  = modem_chg_i && ier_i[EN_MDM];
    end

    // Purpose: pick the highest-priority qualified source.
    always_comb begin
        if (line_c)      code_c = IID_LINE;
        else if (rx_c)   code_c = IID_RX;
        else if (tmo_c)  code_c = IID_TMO;
        else if (thr_c)  code_c = IID_THR;
        else if (mdm_c)  code_c = IID_MDM;
        else             code_c = IID_NONE;
    end

    assign irq_o    = line_c || rx_c || tmo_c || thr_c || mdm_c;
    assign iid_o    = code_c;
    assign is_thr_o = (code_c == IID_THR);
endmodule

// File: rtl/uart_irq_combiner.sv
// Module: top of the UART interrupt combiner. It ties the pending-flag
// tracker to the priority encoder and forces the idle outputs while reset
// is held. Assumes a synchronous active-low reset; the outputs are
// combinational from the inputs and the one internal flag.
module uart_irq_combiner
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_err_i,
    input  logic             rx_avail_i,
    input  logic             char_tmo_i,
    input  logic             thr_empty_i,
    input  logic             modem_chg_i,
    input  logic             fifo_mode_i,
    input  logic [IER_W-1:0] ier_i,
    input  logic             id_read_i,
    input  logic             thr_write_i,
    output logic             irq_o,
    output logic [IID_W-1:0] iid_o
);
    logic             thr_pend;
    logic             enc_irq;
    logic [IID_W-1:0] enc_iid;
    logic             enc_is_thr;

    uart_irq_thr_tracker u_thr (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_empty_i (thr_empty_i),
        .thr_en_i    (ier_i[EN_THR]),
        .thr_write_i (thr_write_i),
        .id_read_i   (id_read_i),
        .id_is_thr_i (enc_is_thr),
        .pend_o      (thr_pend)
    );

    uart_irq_prio_enc u_enc (
        .line_err_i  (line_err_i),
        .rx_avail_i  (rx_avail_i),
        .char_tmo_i  (char_tmo_i),
        .thr_pend_i  (thr_pend),
        .modem_chg_i (modem_chg_i),
        .fifo_mode_i (fifo_mode_i),
        .ier_i       (ier_i),
        .irq_o       (enc_irq),
        .iid_o       (enc_iid),
        .is_thr_o    (enc_is_thr)
    );

    // Purpose: hold the idle outputs while reset is asserted.
    always_comb begin
        irq_o = rst_n && enc_irq;
        iid_o = rst_n ? enc_iid : IID_NONE;
    end

    // The request and the no-pending bit of the code always agree.
    assert_irq_matches_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == !iid_o[0]);

    // No timeout code outside FIFO mode.
    assert_no_tmo_outside_fifo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode_i |-> (iid_o != IID_TMO));

    // An enabled line error always wins.
    assert_line_err_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err_i && ier_i[EN_LINE]) |-> (iid_o == IID_LINE));
endmodule

// File: tb/sim_uart_irq_combiner.sv
`timescale 1ns/100ps
module sim_uart_irq_combiner;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       line_err, rx_avail, char_tmo, thr_empty, modem_chg, fifo_mode;
    logic [3:0] ier;
    logic       id_read, thr_write;
    logic       irq;
    logic [3:0] iid;
    int         total = 0;
    int         bad   = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_combiner u0 (
        .clk(clk), .rst_n(rst_n),
        .line_err_i(line_err), .rx_avail_i(rx_avail), .char_tmo_i(char_tmo),
        .thr_empty_i(thr_empty), .modem_chg_i(modem_chg), .fifo_mode_i(fifo_mode),
        .ier_i(ier), .id_read_i(id_read), .thr_write_i(thr_write),
        .irq_o(irq), .iid_o(iid)
    );

    task automatic chk(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Move to the next falling edge; the inputs change there.
    task automatic step();
        @(negedge clk);
    endtask

    // Check both outputs 1 ns after the inputs settle.
    task automatic chk_out(input string req, input logic exp_irq, input logic [3:0] exp_iid);
        #1;
        chk(req, "irq", {3'b0, irq}, {3'b0, exp_irq});
        chk(req, "iid", iid, exp_iid);
    endtask

    // Pulse a transmit-register write to clear the pending flag (R9 path).
    task automatic clear_thr();
        step(); thr_write = 1'b1;
        step(); thr_write = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        line_err = 1'b1; rx_avail = 1'b1; char_tmo = 1'b1; thr_empty = 1'b1;
        modem_chg = 1'b1; fifo_mode = 1'b1; ier = 4'b1111; id_read = 1'b0; thr_write = 1'b0;
        step();
        chk_out("R10", 1'b0, 4'b0001);
        step();
        line_err = 1'b0; rx_avail = 1'b0; char_tmo = 1'b0; modem_chg = 1'b0; ier = 4'b0000;
        step(); rst_n = 1'b1;
        chk_out("R10", 1'b0, 4'b0001);
    endtask

    task automatic t_mask();
        step();
        ier = 4'b0000; line_err = 1'b1; rx_avail = 1'b1; modem_chg = 1'b1;
        chk_out("R1", 1'b0, 4'b0001);
        ier = 4'b1000; line_err = 1'b0; rx_avail = 1'b0;
        chk_out("R1", 1'b1, 4'b0000);
        ier = 4'b0000;
        chk_out("R5", 1'b0, 4'b0001);
        modem_chg = 1'b0;
    endtask

    task automatic t_priority();
        ier = 4'b1101; fifo_mode = 1'b1;
        line_err = 1'b1; rx_avail = 1'b1; char_tmo = 1'b1; modem_chg = 1'b1;
        chk_out("R3", 1'b1, 4'b0110);
        line_err = 1'b0;
        chk_out("R3", 1'b1, 4'b0100);
        rx_avail = 1'b0;
        chk_out("R4", 1'b1, 4'b1100);
        fifo_mode = 1'b0;
        chk_out("R2", 1'b1, 4'b0000);
        modem_chg = 1'b0;
        chk_out("R2", 1'b0, 4'b0001);
        char_tmo = 1'b0; fifo_mode = 1'b1;
    endtask

    task automatic t_enable_rise();
        step(); ier = 4'b0000; thr_empty = 1'b1;
        clear_thr();
        chk_out("R9", 1'b0, 4'b0001);
        step(); ier = 4'b0010;
        step();
        chk_out("R7", 1'b1, 4'b0010);
    endtask

    task automatic t_read_clear();
        step(); id_read = 1'b1;
        step(); id_read = 1'b0;
        chk_out("R8", 1'b0, 4'b0001);
    endtask

    task automatic t_edge_and_write();
        step(); ier = 4'b1010; thr_empty = 1'b0;
        step(); thr_empty = 1'b1;
        step();
        chk_out("R6", 1'b1, 4'b0010);
        modem_chg = 1'b1;
        chk_out("R3", 1'b1, 4'b0010);
        step(); thr_write = 1'b1; thr_empty = 1'b0;
        step(); thr_write = 1'b0;
        chk_out("R9", 1'b1, 4'b0000);
        modem_chg = 1'b0;
    endtask

    task automatic t_read_other();
        step(); ier = 4'b0110; thr_empty = 1'b1;
        step();
        chk_out("R6", 1'b1, 4'b0010);
        line_err = 1'b1;
        chk_out("R4", 1'b1, 4'b0110);
        step(); id_read = 1'b1;
        step(); id_read = 1'b0; line_err = 1'b0;
        chk_out("R8", 1'b1, 4'b0010);
    endtask

    task automatic t_write_wins();
        step(); thr_empty = 1'b0;
        clear_thr();
        step(); thr_empty = 1'b1; thr_write = 1'b1;
        step(); thr_write = 1'b0;
        chk_out("R9", 1'b0, 4'b0001);
    endtask

    task automatic t_reset_clears();
        step(); thr_empty = 1'b0;
        step(); thr_empty = 1'b1;
        step();
        chk_out("R6", 1'b1, 4'b0010);
        rst_n = 1'b0;
        step(); rst_n = 1'b1;
        chk_out("R10", 1'b0, 4'b0001);
    endtask

    initial begin
        t_reset();
        t_mask();
        t_priority();
        t_enable_rise();
        t_read_clear();
        t_edge_and_write();
        t_read_other();
        t_write_wins();
        t_reset_clears();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule